// File: doc/BRIEF.md
# Doorbell Mailbox Register Block

This block is a small register-mapped mailbox between a host processor and a remote controller. The host has a plain 32-bit register bus with an 8-bit byte address, separate read and write strobes and write data. It places payload words in an outbound buffer and writes a command word. The remote controller gets a one-cycle doorbell and finds the command and outbound payload on its own ports. It puts any result words into an inbound buffer and then signals completion with a done strobe, an error flag and an 8-bit error code.

While a command is outstanding the block reports busy, and it ignores further command writes. When the remote finishes, busy drops and the error outcome is latched in the status word. If the command asked for it, the host also gets a one-cycle completion interrupt and a sticky flag in status. The host clears that flag by writing a one to the flag's bit position. Host reads are combinational: read data follows the address in the same cycle the read strobe is high.

Top module: `mbx_doorbell`

## Requirements
- R1: After reset the status word (offset 0x04) reads only the initiator id parameter in bits 15:8, with every other bit zero. The doorbell and host interrupt outputs are low.
- R2: A host write to offset 0x00 while idle latches the command word and presents it on `rmt_cmd`. The command fields are: code in bits 7:0, completion-interrupt request in bit 8, sub-command id in bits 15:12, payload size in bits 23:16. `rmt_doorbell` is high for exactly the one cycle after the write edge.
- R3: An accepted command sets busy (status bit 0) at the same clock edge, so a status read in the next cycle returns busy as 1. The command's sub-command id is copied into status bits 7:4.
- R4: A command write while busy is ignored: no doorbell, and `rmt_cmd` and the status word are unchanged.
- R5: A done strobe while busy clears busy at the next edge. It latches `rmt_err` into status bit 1 and `rmt_err_code` into status bits 23:16. A done strobe while idle changes nothing. Accepting a new command clears the error bit and the error code.
- R6: When the accepted command had bit 8 set, completion gives a one-cycle `host_irq` pulse and sets the sticky flag in status bit 2. When bit 8 was clear, neither happens.
- R7: A host write to offset 0x04 with bit 2 set clears the flag. Every other status bit, and any such write with bit 2 clear, leaves status unchanged.
- R8: Host writes to offsets 0x80, 0x84, 0x88 and 0x8C fill outbound words 0 to 3. The remote reads word `rmt_ob_idx` on `rmt_ob_data`.
- R9: The remote writes inbound word `rmt_ib_idx` with `rmt_ib_we`. A host read at a word-aligned offset 0x90 to 0x9C returns the whole word. A read with nonzero address bits 1:0 returns that byte lane zero-extended in bits 7:0.
- R10: Host reads of the command offset, of the outbound buffer and of any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 8 | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational, zero when not reading |
| host_irq | output | 1 | One-cycle completion interrupt to host |
| rmt_doorbell | output | 1 | One-cycle doorbell to remote |
| rmt_cmd | output | 32 | Latched command word |
| rmt_ob_idx | input | 2 | Outbound word index for remote read |
| rmt_ob_data | output | 32 | Selected outbound word |
| rmt_ib_we | input | 1 | Remote inbound write enable |
| rmt_ib_idx | input | 2 | Inbound word index for remote write |
| rmt_ib_data | input | 32 | Remote inbound write data |
| rmt_done | input | 1 | Remote completion strobe |
| rmt_err | input | 1 | Completion error flag |
| rmt_err_code | input | 8 | Completion error code |

## Verification
The controller's busy, error, flag and sub-id state all show up in the status word, so a corrupted state is visible on the first host read that follows. The directed scenarios read status one cycle after each command or done edge. A busy bit that stuck or dropped early would show in two ways: a doorbell on a command that should have been refused, or a done that failed to latch its error code. Both appear within a cycle on `rmt_doorbell` or in the next status read. A lost interrupt-request bit shows as a missing or extra `host_irq` pulse in the exact cycle after done.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int WORD_W = 32;

  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [3:0] OB_PAGE  = 4'h8;
  localparam logic [3:0] IB_PAGE  = 4'h9;

  localparam int ST_BUSY = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_FLAG = 2;

  typedef struct packed {
    logic [7:0] spare_hi;
    logic [7:0] size;
    logic [3:0] sub;
    logic [2:0] spare_lo;
    logic       ioc;
    logic [7:0] code;
  } cmd_t;

  function automatic logic [WORD_W-1:0] pack_status(
    input logic busy, input logic err, input logic flag,
    input logic [3:0] sub, input logic [7:0] init_id, input logic [7:0] ecode);
    pack_status = {8'h00, ecode, init_id, sub, 1'b0, flag, err, busy};
  endfunction

  function automatic logic [WORD_W-1:0] byte_lane(
    input logic [WORD_W-1:0] w, input logic [1:0] lane);
    byte_lane = {24'h0, w[8*lane +: 8]};
  endfunction
endpackage

// File: rtl/mbx_wbuf.sv
module mbx_wbuf #(
  parameter int WORDS = 4,
  parameter int IDX_W = $clog2(WORDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [IDX_W-1:0]            widx,
  input  logic [mbx_pkg::WORD_W-1:0]  wdata,
  input  logic [IDX_W-1:0]            ridx,
  output logic [mbx_pkg::WORD_W-1:0]  rdata
);
  logic [mbx_pkg::WORD_W-1:0] mem [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            mem[g] <= '0;
      else if (we && widx == IDX_W'(g))      mem[g] <= wdata;
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter logic [7:0] INIT_ID = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              stat_wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rmt_done,
  input  logic              rmt_err,
  input  logic [7:0]        rmt_err_code,
  output logic [WORD_W-1:0] status,
  output logic [WORD_W-1:0] cmd_q,
  output logic              doorbell,
  output logic              host_irq
);
  logic       busy_q, err_q, flag_q, ioc_q;
  logic [3:0] sub_q;
  logic [7:0] ecode_q;

  cmd_t cmd_in;
  assign cmd_in = cmd_t'(wdata);

  // named internal events
  logic cmd_accept, done_accept, flag_clear;
  assign cmd_accept  = cmd_wr && !busy_q;
  assign done_accept = rmt_done && busy_q;
  assign flag_clear  = stat_wr && wdata[ST_FLAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      err_q    <= 1'b0;
      flag_q   <= 1'b0;
      ioc_q    <= 1'b0;
      sub_q    <= '0;
      ecode_q  <= '0;
      cmd_q    <= '0;
      doorbell <= 1'b0;
      host_irq <= 1'b0;
    end else begin
      doorbell <= cmd_accept;
      host_irq <= done_accept && ioc_q;
      if (cmd_accept) begin
        cmd_q   <= wdata;
        busy_q  <= 1'b1;
        sub_q   <= cmd_in.sub;
        ioc_q   <= cmd_in.ioc;
        err_q   <= 1'b0;
        ecode_q <= '0;
      end else if (done_accept) begin
        busy_q  <= 1'b0;
        err_q   <= rmt_err;
        ecode_q <= rmt_err_code;
      end
      if (done_accept && ioc_q) flag_q <= 1'b1;
      else if (flag_clear)      flag_q <= 1'b0;
    end
  end

  assign status = pack_status(busy_q, err_q, flag_q, sub_q, INIT_ID, ecode_q);

  AST_DOORBELL_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> $past(cmd_wr) && !$past(status[ST_BUSY])); // R2
  AST_BUSY_WITH_DOORBELL: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> status[ST_BUSY]); // R3
  AST_IGNORED_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && status[ST_BUSY]) |=> $stable(cmd_q) && !doorbell); // R4
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rmt_done && status[ST_BUSY] && !cmd_wr) |=> !status[ST_BUSY]); // R5
  AST_IRQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |=> !host_irq); // R6
  AST_IRQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> status[ST_FLAG]); // R6
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
  import mbx_pkg::*;
#(
  parameter int         BUF_WORDS = 4,
  parameter logic [7:0] INIT_ID   = 8'h5A,
  localparam int        IDX_W     = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              host_irq,
  output logic              rmt_doorbell,
  output logic [WORD_W-1:0] rmt_cmd,
  input  logic [IDX_W-1:0]  rmt_ob_idx,
  output logic [WORD_W-1:0] rmt_ob_data,
  input  logic              rmt_ib_we,
  input  logic [IDX_W-1:0]  rmt_ib_idx,
  input  logic [WORD_W-1:0] rmt_ib_data,
  input  logic              rmt_done,
  input  logic              rmt_err,
  input  logic [7:0]        rmt_err_code
);
  logic cmd_hit, stat_hit, ob_hit, ib_hit;
  assign cmd_hit  = host_addr == OFS_CMD;
  assign stat_hit = host_addr == OFS_STAT;
  assign ob_hit   = host_addr[7:4] == OB_PAGE;
  assign ib_hit   = host_addr[7:4] == IB_PAGE;

  logic [IDX_W-1:0] host_idx;
  assign host_idx = host_addr[IDX_W+1:2];

  logic [WORD_W-1:0] status_w, ib_word;

  mbx_ctrl #(.INIT_ID(INIT_ID)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wr       (host_wr && cmd_hit),
    .stat_wr      (host_wr && stat_hit),
    .wdata        (host_wdata),
    .rmt_done     (rmt_done),
    .rmt_err      (rmt_err),
    .rmt_err_code (rmt_err_code),
    .status       (status_w),
    .cmd_q        (rmt_cmd),
    .doorbell     (rmt_doorbell),
    .host_irq     (host_irq)
  );

  mbx_wbuf #(.WORDS(BUF_WORDS)) u_obuf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (host_wr && ob_hit),
    .widx  (host_idx),
    .wdata (host_wdata),
    .ridx  (rmt_ob_idx),
    .rdata (rmt_ob_data)
  );

  mbx_wbuf #(.WORDS(BUF_WORDS)) u_ibuf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rmt_ib_we),
    .widx  (rmt_ib_idx),
    .wdata (rmt_ib_data),
    .ridx  (host_idx),
    .rdata (ib_word)
  );

  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      if (stat_hit)                          host_rdata = status_w;
      else if (ib_hit && host_addr[1:0] == 2'b00) host_rdata = ib_word;
      else if (ib_hit)                       host_rdata = byte_lane(ib_word, host_addr[1:0]);
    end
  end

  AST_READ_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |-> host_rdata == '0); // R10
endmodule

// File: tb/mbx_doorbell_tb.sv
module mbx_doorbell_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_irq, rmt_doorbell;
  logic [31:0] rmt_cmd, rmt_ob_data;
  logic [1:0]  rmt_ob_idx = '0, rmt_ib_idx = '0;
  logic        rmt_ib_we = 1'b0;
  logic [31:0] rmt_ib_data = '0;
  logic        rmt_done = 1'b0, rmt_err = 1'b0;
  logic [7:0]  rmt_err_code = '0;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mbx_doorbell u_dut (.*);

  localparam logic [31:0] ID_BITS = 32'h0000_5A00;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    host_rd = 1'b0;
  endtask

  task automatic finish_cmd(input logic e, input logic [7:0] code, output logic irq_seen);
    @(negedge clk); rmt_done = 1'b1; rmt_err = e; rmt_err_code = code;
    @(negedge clk); rmt_done = 1'b0; rmt_err = 1'b0; rmt_err_code = '0;
    irq_seen = host_irq;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(8'h04, d);
    chk("R1 status", d, ID_BITS);
    chk("R1 doorbell", {31'b0, rmt_doorbell}, 0);
    chk("R1 irq", {31'b0, host_irq}, 0);
  endtask

  task automatic t_cmd_no_ioc();
    logic [31:0] d; logic irq;
    @(negedge clk); host_addr = 8'h00; host_wdata = 32'h0004_30AB; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
    chk("R2 doorbell pulse", {31'b0, rmt_doorbell}, 1);
    chk("R2 cmd latched", rmt_cmd, 32'h0004_30AB);
    bus_rd(8'h04, d);
    chk("R2 doorbell single", {31'b0, rmt_doorbell}, 0);
    chk("R3 busy and sub", d, ID_BITS | 32'h31);
    // R4 command while busy ignored
    @(negedge clk); host_addr = 8'h00; host_wdata = 32'h0000_1155; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
    chk("R4 no doorbell", {31'b0, rmt_doorbell}, 0);
    chk("R4 cmd kept", rmt_cmd, 32'h0004_30AB);
    bus_rd(8'h04, d);
    chk("R4 status kept", d, ID_BITS | 32'h31);
    finish_cmd(1'b0, 8'h00, irq);
    chk("R6 no irq without request", {31'b0, irq}, 0);
    bus_rd(8'h04, d);
    chk("R5 busy cleared", d, ID_BITS | 32'h30);
    finish_cmd(1'b1, 8'h33, irq);
    bus_rd(8'h04, d);
    chk("R5 idle done ignored", d, ID_BITS | 32'h30);
  endtask

  task automatic t_cmd_ioc();
    logic [31:0] d; logic irq;
    bus_wr(8'h00, 32'h0000_2110);
    finish_cmd(1'b1, 8'h7E, irq);
    chk("R6 irq pulse", {31'b0, irq}, 1);
    @(negedge clk);
    chk("R6 irq single", {31'b0, host_irq}, 0);
    bus_rd(8'h04, d);
    chk("R5 R6 error and flag", d, 32'h007E_5A26);
    bus_wr(8'h04, 32'hFFFF_FFFB);
    bus_rd(8'h04, d);
    chk("R7 no clear without bit2", d, 32'h007E_5A26);
    bus_wr(8'h04, 32'h0000_0004);
    bus_rd(8'h04, d);
    chk("R7 flag cleared", d, 32'h007E_5A22);
    bus_wr(8'h00, 32'h0000_1001);
    bus_rd(8'h04, d);
    chk("R5 accept clears error", d, ID_BITS | 32'h11);
    finish_cmd(1'b0, 8'h00, irq);
  endtask

  task automatic t_buffers();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) bus_wr(8'h80 + 8'(4*i), 32'hA000_0000 + 32'(i * 17));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); rmt_ob_idx = 2'(i);
      #1 chk("R8 outbound word", rmt_ob_data, 32'hA000_0000 + 32'(i * 17));
    end
    @(negedge clk); rmt_ib_we = 1'b1; rmt_ib_idx = 2'd2; rmt_ib_data = 32'hDEAD_BEEF;
    @(negedge clk); rmt_ib_idx = 2'd0; rmt_ib_data = 32'h1234_5678;
    @(negedge clk); rmt_ib_we = 1'b0;
    bus_rd(8'h98, d); chk("R9 inbound word", d, 32'hDEAD_BEEF);
    bus_rd(8'h9B, d); chk("R9 byte lane 3", d, 32'h0000_00DE);
    bus_rd(8'h99, d); chk("R9 byte lane 1", d, 32'h0000_00BE);
    bus_rd(8'h90, d); chk("R9 inbound word 0", d, 32'h1234_5678);
    bus_rd(8'h84, d); chk("R10 outbound read zero", d, 0);
    bus_rd(8'h00, d); chk("R10 command read zero", d, 0);
    bus_rd(8'h40, d); chk("R10 unmapped read zero", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cmd_no_ioc();
    t_cmd_ioc();
    t_buffers();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule